// File: doc/BRIEF.md
# Transmit Event FIFO Controller

This block keeps a short history of finished CAN transmissions. Each time the transmit engine reports a completed message, it presents an event word. The block stores that word in a small circular FIFO. It can also attach a value taken from a free-running 32-bit cycle counter, which serves as a timestamp. Software sees the oldest entry at the tail outputs. It moves on to the next entry by setting a one-shot advance bit in a 7-bit control word.

The same control word carries three more things: a one-shot flush bit, a timestamp enable that only takes effect in configuration mode, and four interrupt enables. The four status conditions are not-empty, half-full, full and sticky overflow. Each is ANDed with its own enable, and the results are ORed into a single interrupt line. Hardware clears the flush and advance bits, so software sets them and then polls until they read zero.

Top module: `tx_event_fifo`

## Requirements
- R1: After reset, the control word reads 0, occupancy is 0, and not_empty, half_full, full, overflow and irq are all 0.
- R2: An accepted event is stored in arrival order. tail_data shows the oldest stored entry, and occupancy rises by one on the clock edge where evt_valid is sampled high.
- R3: Writing 1 to control bit 1 (advance) sets that bit, which reads 1 for exactly one cycle. On the following edge the tail moves on by exactly one entry and the bit reads 0 again. Writing 0 to it changes nothing.
- R4: An advance while the FIFO is empty is ignored. Occupancy stays 0 and not_empty stays 0.
- R5: If an event write and a pending advance fall on the same edge with the FIFO not empty, occupancy is unchanged and the tail moves to the next entry.
- R6: Writing 1 to control bit 0 (flush) sets that bit, which reads 1 for one cycle. On the next edge the FIFO is emptied, the overflow flag is cleared and the bit reads 0.
- R7: An event that arrives while the FIFO is full, with no advance on that edge, is dropped. Occupancy stays at DEPTH, the tail is unchanged, and the sticky overflow flag is set. It stays set until a flush.
- R8: Control bit 2 (timestamp enable) only changes on a control write made while op_mode equals 3'b100. Writes in any other mode leave it as it was.
- R9: With timestamping on, a stored entry has tail_stamped = 1 and tail_stamp equal to the counter value on the edge where the entry was written. The counter is 0 on the first edge after reset and rises by one per edge. With timestamping off, tail_stamped = 0 and tail_stamp = 0.
- R10: half_full is 1 exactly when occupancy >= DEPTH/2. full is 1 exactly when occupancy == DEPTH. not_empty is 1 exactly when occupancy != 0.
- R11: irq = (not_empty & bit 3) | (half_full & bit 4) | (full & bit 5) | (overflow & bit 6), using the control word bits.
- R12: ctl_rd_data presents {ovf_en[6], full_en[5], half_en[4], ne_en[3], stamp_en[2], advance[1], flush[0]}. The four enables load on every control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_mode | input | 3 | Controller operating mode; 3'b100 is configuration |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 7 | Control word write value |
| ctl_rd_data | output | 7 | Current control word |
| evt_valid | input | 1 | Transmit event present this cycle |
| evt_data | input | DATA_W | Transmit event word |
| tail_data | output | DATA_W | Event word at the tail |
| tail_stamp | output | STAMP_W | Timestamp at the tail, 0 if none |
| tail_stamped | output | 1 | Tail entry carries a timestamp |
| occupancy | output | $clog2(DEPTH)+1 | Number of stored entries |
| not_empty | output | 1 | Occupancy is non-zero |
| half_full | output | 1 | Occupancy is at least DEPTH/2 |
| full | output | 1 | Occupancy equals DEPTH |
| overflow | output | 1 | Sticky flag for a dropped event |
| irq | output | 1 | Masked OR of the four status flags |

## Verification
Control writes and event writes take effect on the next edge, so the control word, occupancy, tail and flags are checked at the falling edge that follows. The two one-shot bits need one more edge to act. Their set state is checked one falling edge after the write, and their effect (tail movement, emptying) one falling edge after that. The status flags and irq are combinational from registered state. A whole enable-mask sweep is therefore checked at every occupancy from 0 to DEPTH, and again with overflow set. Expected timestamps come from a bench cycle counter that is read at the falling edge where evt_valid is raised.

// File: rtl/tef_pkg.sv
package tef_pkg;

   localparam logic [2:0] MODE_CFG = 3'b100;

   localparam int N_SRC   = 4;
   localparam int CTL_W   = 3 + N_SRC;
   localparam int B_FLUSH = 0;
   localparam int B_ADV   = 1;
   localparam int B_STAMP = 2;
   localparam int B_EN_LO = 3;

   localparam int SRC_NE   = 0;
   localparam int SRC_HALF = 1;
   localparam int SRC_FULL = 2;
   localparam int SRC_OVF  = 3;

   typedef struct packed {
      logic [N_SRC-1:0] irq_en;
      logic             stamp_en;
      logic             advance;
      logic             flush;
   } ctl_t;

endpackage

// File: rtl/tef_ctrl.sv
module tef_ctrl
   import tef_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       op_mode,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wr_data,
   output ctl_t             ctl
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else begin
         ctl.flush   <= wr_en && wr_data[B_FLUSH];
         ctl.advance <= wr_en && wr_data[B_ADV];
         if (wr_en) begin
            ctl.irq_en <= wr_data[B_EN_LO +: N_SRC];
         end
         if (wr_en && (op_mode == MODE_CFG)) begin
            ctl.stamp_en <= wr_data[B_STAMP];
         end
      end
   end

   // R8: timestamp enable is frozen outside configuration mode
   a_r8_stamp_locked : assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode != MODE_CFG) |=> (ctl.stamp_en == $past(ctl.stamp_en)));

   // R3: advance is a one-shot that hardware clears
   a_r3_advance_one_shot : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.advance && !wr_en) |=> !ctl.advance);

   // R6: flush is a one-shot that hardware clears
   a_r6_flush_one_shot : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.flush && !wr_en) |=> !ctl.flush);

endmodule

// File: rtl/tef_stamp.sv
module tef_stamp #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] value
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) value <= '0;
      else        value <= value + W'(1);
   end

endmodule

// File: rtl/tef_store.sv
module tef_store #(
   parameter  int DEPTH   = 4,
   parameter  int DATA_W  = 16,
   parameter  int STAMP_W = 32,
   localparam int PTR_W   = $clog2(DEPTH),
   localparam int CNT_W   = PTR_W + 1,
   localparam int ENT_W   = 1 + STAMP_W + DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               advance,
   input  logic               stamp_en,
   input  logic               push_valid,
   input  logic [DATA_W-1:0]  push_data,
   input  logic [STAMP_W-1:0] stamp_val,
   output logic [DATA_W-1:0]  tail_data,
   output logic [STAMP_W-1:0] tail_stamp,
   output logic               tail_stamped,
   output logic [CNT_W-1:0]   count,
   output logic               overflow
);

   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count_q;
   logic             ovf_q;
   logic [ENT_W-1:0] mem [DEPTH];
   logic [ENT_W-1:0] entry, rd_entry;
   logic             is_full, is_empty, pop_fire, push_ok;

   assign is_full  = (count_q == CNT_W'(DEPTH));
   assign is_empty = (count_q == '0);
   assign pop_fire = advance && !is_empty;
   assign push_ok  = push_valid && (!is_full || pop_fire);
   assign entry    = {stamp_en, (stamp_en ? stamp_val : {STAMP_W{1'b0}}), push_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_q <= '0;
         ovf_q   <= 1'b0;
      end else if (flush) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_q <= '0;
         ovf_q   <= 1'b0;
      end else begin
         if (push_ok)  wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop_fire) rd_ptr <= rd_ptr + PTR_W'(1);
         unique case ({push_ok, pop_fire})
            2'b10:   count_q <= count_q + CNT_W'(1);
            2'b01:   count_q <= count_q - CNT_W'(1);
            default: count_q <= count_q;
         endcase
         if (push_valid && !push_ok) ovf_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !flush) mem[wr_ptr] <= entry;
   end

   assign rd_entry     = mem[rd_ptr];
   assign tail_data    = rd_entry[DATA_W-1:0];
   assign tail_stamp   = rd_entry[DATA_W +: STAMP_W];
   assign tail_stamped = rd_entry[ENT_W-1];
   assign count        = count_q;
   assign overflow     = ovf_q;

   // R6: a flush empties the FIFO and clears overflow on the next edge
   a_r6_flush_empties : assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count_q == '0 && !ovf_q));

   // R7: a write to a full FIFO without a pop is dropped and flagged
   a_r7_full_drop : assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && is_full && !advance && !flush) |=> (is_full && ovf_q));

   // R4: advance on an empty FIFO leaves it empty
   a_r4_empty_advance : assert property (@(posedge clk) disable iff (!rst_n)
      (advance && is_empty && !push_valid && !flush) |=> (count_q == '0));

   // R5: simultaneous write and advance keep occupancy
   a_r5_push_pop : assert property (@(posedge clk) disable iff (!rst_n)
      (advance && push_valid && !is_empty && !flush) |=> $stable(count_q));

   // R2: occupancy never exceeds the depth
   a_r2_bounded : assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/tef_irq.sv
module tef_irq #(
   parameter int N = 4
) (
   input  logic [N-1:0] flags,
   input  logic [N-1:0] enables,
   output logic         irq
);

   logic [N-1:0] masked;

   for (genvar g = 0; g < N; g++) begin : g_src
      assign masked[g] = flags[g] & enables[g];
   end

   assign irq = |masked;

endmodule

// File: rtl/tx_event_fifo.sv
module tx_event_fifo
   import tef_pkg::*;
#(
   parameter int DEPTH   = 4,
   parameter int DATA_W  = 16,
   parameter int STAMP_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2:0]             op_mode,
   input  logic                   ctl_wr_en,
   input  logic [6:0]             ctl_wr_data,
   output logic [6:0]             ctl_rd_data,
   input  logic                   evt_valid,
   input  logic [DATA_W-1:0]      evt_data,
   output logic [DATA_W-1:0]      tail_data,
   output logic [STAMP_W-1:0]     tail_stamp,
   output logic                   tail_stamped,
   output logic [$clog2(DEPTH):0] occupancy,
   output logic                   not_empty,
   output logic                   half_full,
   output logic                   full,
   output logic                   overflow,
   output logic                   irq
);

   localparam int CNT_W = $clog2(DEPTH) + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 2");
   end
   if (DATA_W < 1 || STAMP_W < 1) begin : g_bad_width
      $error("DATA_W and STAMP_W must be positive");
   end
   if (CTL_W != 7) begin : g_bad_ctl
      $error("control word layout must be 7 bits");
   end

   ctl_t               ctl;
   logic [STAMP_W-1:0] stamp_now;
   logic [CNT_W-1:0]   count;
   logic [N_SRC-1:0]   flags;

   tef_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_mode (op_mode),
      .wr_en   (ctl_wr_en),
      .wr_data (ctl_wr_data),
      .ctl     (ctl)
   );

   tef_stamp #(.W(STAMP_W)) u_stamp (
      .clk   (clk),
      .rst_n (rst_n),
      .value (stamp_now)
   );

   tef_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .STAMP_W(STAMP_W)) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush        (ctl.flush),
      .advance      (ctl.advance),
      .stamp_en     (ctl.stamp_en),
      .push_valid   (evt_valid),
      .push_data    (evt_data),
      .stamp_val    (stamp_now),
      .tail_data    (tail_data),
      .tail_stamp   (tail_stamp),
      .tail_stamped (tail_stamped),
      .count        (count),
      .overflow     (overflow)
   );

   assign occupancy = count;
   assign not_empty = (count != '0);
   assign half_full = (count >= CNT_W'(DEPTH / 2));
   assign full      = (count == CNT_W'(DEPTH));

   assign flags[SRC_NE]   = not_empty;
   assign flags[SRC_HALF] = half_full;
   assign flags[SRC_FULL] = full;
   assign flags[SRC_OVF]  = overflow;

   tef_irq #(.N(N_SRC)) u_irq (
      .flags   (flags),
      .enables (ctl.irq_en),
      .irq     (irq)
   );

   assign ctl_rd_data = ctl;

endmodule

// File: tb/sim_tx_event_fifo.sv
module sim_tx_event_fifo;

   localparam int DEPTH = 4;
   localparam int DW    = 16;
   localparam int SW    = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    op_mode = 3'b000;
   logic          ctl_wr_en = 1'b0;
   logic [6:0]    ctl_wr_data = '0;
   logic [6:0]    ctl_rd_data;
   logic          evt_valid = 1'b0;
   logic [DW-1:0] evt_data = '0;
   logic [DW-1:0] tail_data;
   logic [SW-1:0] tail_stamp;
   logic          tail_stamped;
   logic [2:0]    occupancy;
   logic          not_empty, half_full, full, overflow, irq;

   int errors = 0;
   int checks = 0;
   logic [SW-1:0] bc;
   logic [DW-1:0] q_data[$];
   logic [SW-1:0] q_stamp[$];

   always #2 clk = ~clk;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) bc <= '0;
      else        bc <= bc + 1;

   tx_event_fifo #(.DEPTH(DEPTH), .DATA_W(DW), .STAMP_W(SW)) u0 (
      .clk, .rst_n, .op_mode, .ctl_wr_en, .ctl_wr_data, .ctl_rd_data,
      .evt_valid, .evt_data, .tail_data, .tail_stamp, .tail_stamped,
      .occupancy, .not_empty, .half_full, .full, .overflow, .irq
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic ctl_write(input logic [6:0] d);
      ctl_wr_en = 1'b1; ctl_wr_data = d;
      @(negedge clk);
      ctl_wr_en = 1'b0;
   endtask

   task automatic push(input logic [DW-1:0] d, input bit stamped, input bit accepted);
      evt_valid = 1'b1; evt_data = d;
      if (accepted) begin
         q_data.push_back(d);
         q_stamp.push_back(stamped ? bc : '0);
      end
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic check_flags(input int n, input bit ovf);
      chk("R10 occupancy", 64'(occupancy), 64'(n));
      chk("R10 not_empty", 64'(not_empty), 64'(n != 0));
      chk("R10 half_full", 64'(half_full), 64'(n >= DEPTH/2));
      chk("R10 full", 64'(full), 64'(n == DEPTH));
      chk("R7 overflow", 64'(overflow), 64'(ovf));
   endtask

   task automatic irq_sweep(input int n, input bit ovf);
      for (int m = 0; m < 16; m++) begin
         logic [3:0] f;
         logic [3:0] mm;
         mm = 4'(m);
         f = {ovf, n == DEPTH, n >= DEPTH/2, n != 0};
         ctl_write({mm, 3'b100});
         chk("R12 enables readback", 64'(ctl_rd_data[6:3]), 64'(mm));
         chk("R11 irq", 64'(irq), 64'(|(f & mm)));
      end
   endtask

   task automatic check_tail(input string req);
      chk({req, " tail_data"}, 64'(tail_data), 64'(q_data[0]));
      chk({req, " tail_stamp"}, 64'(tail_stamp), 64'(q_stamp[0]));
      chk({req, " tail_stamped"}, 64'(tail_stamped), 64'(q_stamp[0] != 0));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ctl", 64'(ctl_rd_data), 64'h0);
      chk("R1 occupancy", 64'(occupancy), 64'h0);
      chk("R1 flags", 64'({not_empty, half_full, full, overflow}), 64'h0);
      chk("R1 irq", 64'(irq), 64'h0);

      // R12 layout, R8 stamp write ignored outside config
      ctl_write(7'h7C);
      chk("R8 stamp ignored in mode 000", 64'(ctl_rd_data), 64'h78);
      op_mode = 3'b101;
      ctl_write(7'h7C);
      chk("R8 stamp ignored in mode 101", 64'(ctl_rd_data), 64'h78);
      op_mode = 3'b000;

      // R9 unstamped entry
      push(16'h1234, 1'b0, 1'b1);
      chk("R2 occupancy after push", 64'(occupancy), 64'h1);
      check_tail("R9 unstamped");
      // R3 advance one-shot
      ctl_write(7'h7A);
      chk("R3 advance bit set", 64'(ctl_rd_data), 64'h7A);
      @(negedge clk);
      void'(q_data.pop_front()); void'(q_stamp.pop_front());
      chk("R3 advance bit cleared", 64'(ctl_rd_data), 64'h78);
      chk("R3 occupancy after advance", 64'(occupancy), 64'h0);

      // R8 stamp enabled in configuration mode
      op_mode = 3'b100;
      ctl_write(7'h7C);
      chk("R8 stamp set in mode 100", 64'(ctl_rd_data), 64'h7C);
      op_mode = 3'b000;

      check_flags(0, 1'b0);
      irq_sweep(0, 1'b0);
      // R2 fill with stamps, exhaustive flag/irq per level
      for (int i = 0; i < DEPTH; i++) begin
         push(16'hA000 + 16'(i), 1'b1, 1'b1);
         check_flags(i + 1, 1'b0);
         check_tail("R2 R9 fill");
         irq_sweep(i + 1, 1'b0);
      end
      // R7 overflow
      push(16'hBEEF, 1'b1, 1'b0);
      check_flags(DEPTH, 1'b1);
      check_tail("R7 tail unchanged");
      irq_sweep(DEPTH, 1'b1);

      // drain: R3 one entry per advance, overflow sticky
      for (int k = DEPTH; k > 0; k--) begin
         ctl_write(7'h7E);
         @(negedge clk);
         void'(q_data.pop_front()); void'(q_stamp.pop_front());
         check_flags(k - 1, 1'b1);
         if (k > 1) check_tail("R3 drain");
         irq_sweep(k - 1, 1'b1);
      end

      // R4 advance on empty
      ctl_write(7'h7E);
      @(negedge clk);
      chk("R4 occupancy stays 0", 64'(occupancy), 64'h0);
      chk("R4 not_empty stays 0", 64'(not_empty), 64'h0);

      // R5 simultaneous push and advance
      push(16'hC001, 1'b1, 1'b1);
      push(16'hC002, 1'b1, 1'b1);
      ctl_write(7'h7E);
      push(16'hC003, 1'b1, 1'b1);
      void'(q_data.pop_front()); void'(q_stamp.pop_front());
      chk("R5 occupancy unchanged", 64'(occupancy), 64'h2);
      check_tail("R5 tail moved");

      // R3 writing 0 to advance has no effect
      ctl_write(7'h7C);
      @(negedge clk);
      chk("R3 zero write no effect", 64'(occupancy), 64'h2);
      check_tail("R3 zero write tail");

      // R6 flush
      ctl_write(7'h7D);
      chk("R6 flush bit set", 64'(ctl_rd_data), 64'h7D);
      @(negedge clk);
      chk("R6 flush bit cleared", 64'(ctl_rd_data), 64'h7C);
      check_flags(0, 1'b0);
      chk("R6 irq after flush", 64'(irq), 64'h0);
      q_data.delete(); q_stamp.delete();

      // R9 stamping off again in config mode
      op_mode = 3'b100;
      ctl_write(7'h78);
      op_mode = 3'b000;
      chk("R8 stamp cleared in mode 100", 64'(ctl_rd_data), 64'h78);
      push(16'h5A5A, 1'b0, 1'b1);
      check_tail("R9 stamp off");
      chk("R2 tail after flush", 64'(tail_data), 64'h5A5A);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule